// File: doc/BRIEF.md
# Page-mode DRAM controller with refresh scheduling

This block sits between a synchronous host and one asynchronous fast-page-mode DRAM of 2048 rows by 1024 columns by 8 bits. The host hands it single-byte reads and writes through a valid/ready port carrying a 21-bit byte address. The controller turns each request into the DRAM strobe sequence on a shared 11-bit address bus: the row is presented and taken on the falling RAS edge, and the column is then taken on the falling CAS edge. Write data goes out through separate data-out and drive-enable signals, and read data comes back from a data-in signal.

After an access the row stays open. A later request to the same row, where the row is address bits [20:10], therefore needs only a new CAS cycle. A request to another row closes the page, waits out the precharge and opens the new row. A free-running timer asks for one CAS-before-RAS refresh per interval. The default is 1560 cycles, which is 2048 rows in 32 ms at 100 MHz. A pending refresh blocks new host requests and closes any open page before the refresh strobes start. RAS low time is capped, so a long run of page hits is broken up.

Every DRAM timing interval is a parameter counted in controller clock cycles.

Top module: `fpm_dram_ctrl`

## Requirements
- R1: During reset and right after it, ras_n, cas_n, we_n and oe_n are high, and dq_oe and rd_valid are low.
- R2: The row driven at the falling RAS edge equals request address bits [20:10]. The column driven at the falling CAS edge equals bits [9:0], zero-extended to 11 bits.
- R3: A write drives we_n low with dq_oe high and dq_out equal to the request byte when CAS falls. dq_oe is never high while we_n is high.
- R4: A read returns the DRAM byte on rd_data with a one-cycle rd_valid pulse exactly RD_LAT cycles after its CAS falling edge. Reads complete in request order. oe_n is low only during read CAS cycles.
- R5: A request whose row equals the open row is served with a CAS cycle only, without a new RAS falling edge.
- R6: A request to a different row closes the page. RAS stays high for at least T_RP cycles before every RAS falling edge.
- R7: A refresh starts at least once every REF_INTERVAL cycles plus a bounded service latency. During a refresh CAS is already low in the cycle before RAS falls.
- R8: While a refresh is pending, no host request is accepted. The refresh starts only from a closed page, after at least T_RP cycles of RAS high.
- R9: RAS never stays low for more than RAS_MAX cycles, even under a continuous stream of page hits.
- R10: Every RAS low period lasts at least T_RAS_MIN cycles.
- R11: Every access CAS low period lasts exactly T_CAS cycles. CAS is high for at least T_CP cycles before each access CAS falling edge.
- R12: The address bus is unchanged for at least T_ASR cycles before a row RAS falling edge and for at least T_ASC cycles before an access CAS falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Request accepted at this clock edge when valid |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 21 | Byte address: [20:10] row, [9:0] column |
| req_wdata | input | 8 | Write byte |
| rd_valid | output | 1 | One-cycle pulse marking returned read data |
| rd_data | output | 8 | Returned read byte |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write select, low = write |
| dram_oe_n | output | 1 | Output enable of the DRAM, active low |
| dram_addr | output | 11 | Multiplexed row/column address |
| dq_out | output | 8 | Byte driven onto the data bus |
| dq_oe | output | 1 | Enables the data bus driver |
| dq_in | input | 8 | Byte read from the data bus |

## Verification
The main path is driven with four access patterns. Scattered writes and reads at the address corners (all zeros, all ones, row-only and column-only patterns) show whether the row/column split and the data path are right. A short run in one row separates a page hit from a reopen by counting RAS edges. Alternating rows show that every miss pays a full precharge. A long stream of hits in one row is allowed to run into both the RAS low cap and the refresh timer, and a behavioural DRAM model measures every strobe interval while the address queue confirms order and placement.

// File: rtl/fpm_pkg.sv
package fpm_pkg;
  localparam int ROW_W  = 11;
  localparam int COL_W  = 10;
  localparam int DATA_W = 8;
  localparam int ADDR_W = ROW_W + COL_W;
  localparam int BUS_W  = ROW_W;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ROW_SETUP,
    ST_ROW_HOLD,
    ST_COL_SETUP,
    ST_CAS,
    ST_OPEN,
    ST_PRECHARGE,
    ST_REF_CAS,
    ST_REF_RAS
  } seq_state_e;

  function automatic logic [ROW_W-1:0] row_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:COL_W];
  endfunction

  function automatic logic [COL_W-1:0] col_of(input logic [ADDR_W-1:0] a);
    return a[COL_W-1:0];
  endfunction

  function automatic logic [BUS_W-1:0] col_on_bus(input logic [COL_W-1:0] c);
    return BUS_W'(c);
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/fpm_refresh_timer.sv
module fpm_refresh_timer #(
  parameter int REF_INTERVAL = 1560
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_ack,
  output logic ref_pending
);
  localparam int W = $clog2(REF_INTERVAL + 1);

  logic [W-1:0] cnt_q;
  logic         tick;

  assign tick = (cnt_q == W'(REF_INTERVAL - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q       <= '0;
      ref_pending <= 1'b0;
    end else begin
      cnt_q <= tick ? '0 : cnt_q + 1'b1;
      if (tick)         ref_pending <= 1'b1;
      else if (ref_ack) ref_pending <= 1'b0;
    end
  end

  // R7: a refresh is only acknowledged when one was requested
  assert_ack_needs_pending_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ref_ack |-> ref_pending);
  // R7: every interval expiry leaves a refresh request behind
  assert_tick_sets_pending_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> ref_pending);
endmodule

// File: rtl/fpm_ras_guard.sv
module fpm_ras_guard #(
  parameter int RAS_MAX   = 1000,
  parameter int T_RAS_MIN = 6,
  parameter int CNT_W     = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ras_n,
  output logic [CNT_W-1:0] ras_cnt
);
  // ras_cnt = number of completed RAS-low cycles before the current one
  always_ff @(posedge clk) begin
    if (!rst_n)              ras_cnt <= '0;
    else if (ras_n)          ras_cnt <= '0;
    else if (ras_cnt != '1)  ras_cnt <= ras_cnt + 1'b1;
  end

  assert_ras_low_cap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !ras_n |-> (ras_cnt < CNT_W'(RAS_MAX)));
  assert_ras_low_min_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |-> ($past(ras_cnt) >= CNT_W'(T_RAS_MIN - 1)));
endmodule

// File: rtl/fpm_seq.sv
module fpm_seq
  import fpm_pkg::*;
#(
  parameter int T_ASR     = 1,
  parameter int T_RAH     = 1,
  parameter int T_ASC     = 1,
  parameter int T_CP      = 1,
  parameter int T_CAS     = 2,
  parameter int T_RP      = 4,
  parameter int T_RAS_MIN = 6,
  parameter int T_CSR     = 1,
  parameter int RD_LAT    = 2,
  parameter int RAS_MAX   = 1000,
  parameter int CNT_W     = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  input  logic              ref_pending,
  output logic              ref_ack,
  input  logic [CNT_W-1:0]  ras_cnt,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic              oe_n,
  output logic [BUS_W-1:0]  addr,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe,
  input  logic [DATA_W-1:0] dq_in
);
  localparam int T_COLW    = max2(T_ASC, T_CP);
  localparam int ACC_LEN   = T_COLW + T_CAS;
  localparam int HIT_LIMIT = RAS_MAX - ACC_LEN - 1;
  localparam int TMR_MAX   = max2(max2(max2(T_ASR, T_RAH), max2(T_COLW, T_CAS)),
                                  max2(max2(T_RP, T_RAS_MIN), T_CSR));
  localparam int TMR_W     = $clog2(TMR_MAX + 1);
  localparam logic [CNT_W-1:0] HIT_LIM_C = CNT_W'(HIT_LIMIT);
  localparam logic [CNT_W-1:0] MIN_C     = CNT_W'(T_RAS_MIN - 1);
  localparam logic [TMR_W-1:0] CAP_AT    = TMR_W'(T_CAS - RD_LAT);

  seq_state_e         state_q, state_d;
  logic [TMR_W-1:0]   tmr_q, tmr_d;
  logic [ROW_W-1:0]   open_row_q;
  logic [COL_W-1:0]   col_q;
  logic [DATA_W-1:0]  wdata_q;
  logic               we_q;

  // named events used by the assertions
  logic row_hit, under_lim, accept, close_want, min_ok, done, capture;

  function automatic logic [TMR_W-1:0] dur_of(input seq_state_e s);
    case (s)
      ST_ROW_SETUP: return TMR_W'(T_ASR - 1);
      ST_ROW_HOLD:  return TMR_W'(T_RAH - 1);
      ST_COL_SETUP: return TMR_W'(T_COLW - 1);
      ST_CAS:       return TMR_W'(T_CAS - 1);
      ST_PRECHARGE: return TMR_W'(T_RP - 1);
      ST_REF_CAS:   return TMR_W'(T_CSR - 1);
      ST_REF_RAS:   return TMR_W'(T_RAS_MIN - 1);
      default:      return '0;
    endcase
  endfunction

  assign done       = (tmr_q == '0);
  assign row_hit    = (row_of(req_addr) == open_row_q);
  assign under_lim  = (ras_cnt < HIT_LIM_C);
  assign min_ok     = (ras_cnt >= MIN_C);
  assign close_want = ref_pending || (req_valid && !row_hit) || !under_lim;

  always_comb begin
    case (state_q)
      ST_IDLE: req_ready = !ref_pending;
      ST_OPEN: req_ready = !ref_pending && row_hit && under_lim;
      default: req_ready = 1'b0;
    endcase
  end

  assign accept = req_valid && req_ready;

  always_comb begin
    state_d = state_q;
    ref_ack = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (ref_pending) begin
          ref_ack = 1'b1;
          state_d = ST_REF_CAS;
        end else if (accept) begin
          state_d = ST_ROW_SETUP;
        end
      end
      ST_ROW_SETUP: if (done) state_d = ST_ROW_HOLD;
      ST_ROW_HOLD:  if (done) state_d = ST_COL_SETUP;
      ST_COL_SETUP: if (done) state_d = ST_CAS;
      ST_CAS:       if (done) state_d = ST_OPEN;
      ST_OPEN: begin
        if (accept)                  state_d = ST_COL_SETUP;
        else if (close_want && min_ok) state_d = ST_PRECHARGE;
      end
      ST_PRECHARGE: if (done) state_d = ST_IDLE;
      ST_REF_CAS:   if (done) state_d = ST_REF_RAS;
      ST_REF_RAS:   if (done) state_d = ST_PRECHARGE;
      default:      state_d = ST_PRECHARGE;
    endcase
    if (state_d != state_q) tmr_d = dur_of(state_d);
    else                    tmr_d = done ? tmr_q : tmr_q - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= ST_PRECHARGE;
      tmr_q      <= TMR_W'(T_RP - 1);
      open_row_q <= '0;
      col_q      <= '0;
      wdata_q    <= '0;
      we_q       <= 1'b0;
    end else begin
      state_q <= state_d;
      tmr_q   <= tmr_d;
      if (accept) begin
        open_row_q <= row_of(req_addr);
        col_q      <= col_of(req_addr);
        wdata_q    <= req_wdata;
        we_q       <= req_we;
      end
    end
  end

  assign capture = (state_q == ST_CAS) && !we_q && (tmr_q == CAP_AT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= capture;
      if (capture) rd_data <= dq_in;
    end
  end

  // strobe and bus decode
  logic in_row, col_phase;
  assign in_row    = (state_q == ST_ROW_SETUP) || (state_q == ST_ROW_HOLD);
  assign col_phase = (state_q == ST_COL_SETUP) || (state_q == ST_CAS);

  assign ras_n  = !((state_q == ST_ROW_HOLD) || col_phase ||
                    (state_q == ST_OPEN) || (state_q == ST_REF_RAS));
  assign cas_n  = !((state_q == ST_CAS) || (state_q == ST_REF_CAS) ||
                    (state_q == ST_REF_RAS));
  assign addr   = in_row ? open_row_q : col_on_bus(col_q);
  assign we_n   = !(we_q && col_phase);
  assign dq_oe  = we_q && col_phase;
  assign dq_out = wdata_q;
  assign oe_n   = !(!we_q && (state_q == ST_CAS));

  assert_drive_only_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> (!we_n && oe_n));
  assert_oe_only_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |-> (we_n && !dq_oe && !cas_n));
  assert_rd_single_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);
  assert_hit_keeps_row_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !ras_n) |=> !ras_n);
  assert_cbr_order_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ras_n) && !cas_n) |-> $past(!cas_n));
  assert_refresh_from_closed_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ref_ack |-> (ras_n && cas_n && !accept));
  assert_row_stable_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> $stable(addr));
endmodule

// File: rtl/fpm_dram_ctrl.sv
module fpm_dram_ctrl
  import fpm_pkg::*;
#(
  parameter int T_ASR        = 1,
  parameter int T_RAH        = 1,
  parameter int T_ASC        = 1,
  parameter int T_CP         = 1,
  parameter int T_CAS        = 2,
  parameter int T_RP         = 4,
  parameter int T_RAS_MIN    = 6,
  parameter int T_CSR        = 1,
  parameter int RD_LAT       = 2,
  parameter int RAS_MAX      = 1000,
  parameter int REF_INTERVAL = 1560
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              dram_ras_n,
  output logic              dram_cas_n,
  output logic              dram_we_n,
  output logic              dram_oe_n,
  output logic [BUS_W-1:0]  dram_addr,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe,
  input  logic [DATA_W-1:0] dq_in
);
  localparam int CNT_W = $clog2(RAS_MAX + 1) + 1;

  logic             ref_pending, ref_ack;
  logic [CNT_W-1:0] ras_cnt;

  fpm_refresh_timer #(.REF_INTERVAL(REF_INTERVAL)) u_timer (
    .clk(clk), .rst_n(rst_n), .ref_ack(ref_ack), .ref_pending(ref_pending)
  );

  fpm_ras_guard #(.RAS_MAX(RAS_MAX), .T_RAS_MIN(T_RAS_MIN), .CNT_W(CNT_W)) u_guard (
    .clk(clk), .rst_n(rst_n), .ras_n(dram_ras_n), .ras_cnt(ras_cnt)
  );

  fpm_seq #(
    .T_ASR(T_ASR), .T_RAH(T_RAH), .T_ASC(T_ASC), .T_CP(T_CP), .T_CAS(T_CAS),
    .T_RP(T_RP), .T_RAS_MIN(T_RAS_MIN), .T_CSR(T_CSR), .RD_LAT(RD_LAT),
    .RAS_MAX(RAS_MAX), .CNT_W(CNT_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data),
    .ref_pending(ref_pending), .ref_ack(ref_ack), .ras_cnt(ras_cnt),
    .ras_n(dram_ras_n), .cas_n(dram_cas_n), .we_n(dram_we_n), .oe_n(dram_oe_n),
    .addr(dram_addr), .dq_out(dq_out), .dq_oe(dq_oe), .dq_in(dq_in)
  );
endmodule

// File: tb/test_fpm_dram_ctrl.sv
`timescale 1ns/1ps
module test_fpm_dram_ctrl;
  localparam int T_ASR = 1, T_RAH = 1, T_ASC = 1, T_CP = 1, T_CAS = 2;
  localparam int T_RP = 3, T_RAS_MIN = 5, T_CSR = 1, RD_LAT = 2;
  localparam int RAS_MAX = 40, REF_INT = 300;
  localparam int REF_SLACK = RAS_MAX + T_RP + T_CSR + 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req_valid = 1'b0, req_we = 1'b0;
  logic [20:0] req_addr = '0;
  logic [7:0]  req_wdata = '0, dq_in = '0;
  logic        req_ready, rd_valid, dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n, dq_oe;
  logic [7:0]  rd_data, dq_out;
  logic [10:0] dram_addr;

  always #5 clk = ~clk;

  fpm_dram_ctrl #(
    .T_ASR(T_ASR), .T_RAH(T_RAH), .T_ASC(T_ASC), .T_CP(T_CP), .T_CAS(T_CAS),
    .T_RP(T_RP), .T_RAS_MIN(T_RAS_MIN), .T_CSR(T_CSR), .RD_LAT(RD_LAT),
    .RAS_MAX(RAS_MAX), .REF_INTERVAL(REF_INT)
  ) i_fpm_dram_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data),
    .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n),
    .dram_oe_n(dram_oe_n), .dram_addr(dram_addr),
    .dq_out(dq_out), .dq_oe(dq_oe), .dq_in(dq_in)
  );

  int n_checks = 0, n_err = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // scoreboard state
  logic [7:0]  shadow [logic [20:0]];
  logic [7:0]  mem    [logic [20:0]];
  logic [7:0]  exp_q[$];
  logic [20:0] addr_q[$];

  // DRAM model / monitor state
  int cyc = 0, ref_cnt = 0, ras_falls = 0, last_ref = -1, max_lo = 0;
  int ras_hi = 0, ras_lo = 0, cas_hi = 0, cas_lo = 0, addr_stable = 0, rd_k = 100;
  bit ras_p = 1, cas_p = 1, cas_access = 0;
  logic [10:0] prev_addr = '0, row_m = '0;
  logic [9:0]  col_m = '0;

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      cyc++;
      rd_k++;
      addr_stable = (dram_addr == prev_addr) ? addr_stable + 1 : 1;
      prev_addr = dram_addr;
      // RAS edges
      if (ras_p && !dram_ras_n) begin
        check(ras_hi >= T_RP, "R6", "RAS precharge cycles", ras_hi, T_RP);
        if (!dram_cas_n) begin
          ref_cnt++;
          check(!cas_p, "R7", "CAS low before RAS in refresh", int'(cas_p), 0);
          if (last_ref >= 0)
            check(cyc - last_ref <= REF_INT + REF_SLACK, "R7", "refresh gap",
                  cyc - last_ref, REF_INT + REF_SLACK);
          last_ref = cyc;
        end else begin
          ras_falls++;
          row_m = dram_addr;
          check(addr_stable >= T_ASR + 1, "R12", "row setup cycles", addr_stable, T_ASR + 1);
        end
      end else if (!ras_p && dram_ras_n) begin
        check(ras_lo >= T_RAS_MIN, "R10", "RAS low cycles", ras_lo, T_RAS_MIN);
        check(ras_lo <= RAS_MAX, "R9", "RAS low cycles", ras_lo, RAS_MAX);
        if (ras_lo > max_lo) max_lo = ras_lo;
      end
      // CAS edges
      if (cas_p && !dram_cas_n) begin
        if (!dram_ras_n) begin
          logic [20:0] ea;
          cas_access = 1;
          check(cas_hi >= T_CP, "R11", "CAS precharge cycles", cas_hi, T_CP);
          check(addr_stable >= T_ASC + 1, "R12", "column setup cycles", addr_stable, T_ASC + 1);
          check(dram_addr[10] == 1'b0, "R2", "column bus bit 10", int'(dram_addr[10]), 0);
          col_m = dram_addr[9:0];
          ea = (addr_q.size() > 0) ? addr_q.pop_front() : 21'h0;
          check({row_m, col_m} == ea, "R2", "accessed address", int'({row_m, col_m}), int'(ea));
          if (!dram_we_n) begin
            check(dq_oe == 1'b1, "R3", "data driven on write", int'(dq_oe), 1);
            mem[{row_m, col_m}] = dq_out;
          end else begin
            rd_k = 0;
          end
        end else begin
          cas_access = 0;
          check(ras_hi >= T_RP, "R8", "closed page before refresh", ras_hi, T_RP);
        end
      end else if (!cas_p && dram_cas_n && cas_access) begin
        check(cas_lo == T_CAS, "R11", "CAS low cycles", cas_lo, T_CAS);
      end
      if (dq_oe) check(!dram_we_n, "R3", "drive while we_n high", int'(dram_we_n), 0);
      // read data from the model
      if (!dram_cas_n && !dram_ras_n && dram_we_n)
        dq_in = mem.exists({row_m, col_m}) ? mem[{row_m, col_m}] : 8'h00;
      else
        dq_in = 8'h00;
      // scoreboard pop
      if (rd_valid) begin
        logic [7:0] e;
        check(rd_k == RD_LAT, "R4", "read latency", rd_k, RD_LAT);
        check(exp_q.size() > 0, "R4", "unexpected read", exp_q.size(), 1);
        e = (exp_q.size() > 0) ? exp_q.pop_front() : 8'h00;
        check(rd_data == e, "R4", "read data", int'(rd_data), int'(e));
      end
      // counters
      if (dram_ras_n) begin ras_hi = ras_p ? ras_hi + 1 : 1; end
      else            begin ras_lo = ras_p ? 1 : ras_lo + 1; end
      if (dram_cas_n) begin cas_hi = cas_p ? cas_hi + 1 : 1; end
      else            begin cas_lo = cas_p ? 1 : cas_lo + 1; end
      ras_p = dram_ras_n;
      cas_p = dram_cas_n;
    end
  end

  task automatic issue(input bit we, input logic [20:0] a, input logic [7:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = d;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    @(posedge clk);
    addr_q.push_back(a);
    if (we) shadow[a] = d;
    else    exp_q.push_back(shadow.exists(a) ? shadow[a] : 8'h00);
  endtask

  task automatic drain();
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < 200 && exp_q.size() != 0; i++) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic wait_ref();
    int r = ref_cnt;
    for (int i = 0; i < 2 * REF_INT && ref_cnt == r; i++) @(negedge clk);
    repeat (T_RAS_MIN + T_RP + 2) @(negedge clk);
  endtask

  task automatic finish_run();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(0, "watchdog", "run did not end", 0, 1);
    finish_run();
  end

  initial begin
    int f0, r0;
    logic [20:0] corners [6];
    corners[0] = 21'h000000; corners[1] = 21'h1FFFFF; corners[2] = 21'h1FFC00;
    corners[3] = 21'h0003FF; corners[4] = 21'h155155; corners[5] = 21'h0AAAAA;
    // R1: reset values
    repeat (4) @(negedge clk);
    check(dram_ras_n && dram_cas_n && dram_we_n && dram_oe_n, "R1", "strobes in reset",
          int'({dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n}), 15);
    check(!dq_oe && !rd_valid, "R1", "drive/valid in reset", int'({dq_oe, rd_valid}), 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check(dram_ras_n && dram_cas_n && !dq_oe && !rd_valid, "R1", "state after reset",
          int'({dram_ras_n, dram_cas_n, dq_oe, rd_valid}), 12);

    // R2 R3 R4: corner addresses written then read back
    foreach (corners[i]) issue(1'b1, corners[i], 8'(8'h31 + i * 17));
    foreach (corners[i]) issue(1'b0, corners[i], 8'h00);
    drain();

    // R5: hits inside one row need a single RAS fall
    wait_ref();
    f0 = ras_falls;
    issue(1'b1, {11'h123, 10'h004}, 8'hA5);
    issue(1'b0, {11'h123, 10'h004}, 8'h00);
    issue(1'b1, {11'h123, 10'h3FF}, 8'h5A);
    issue(1'b0, {11'h123, 10'h3FF}, 8'h00);
    drain();
    check(ras_falls - f0 == 1, "R5", "RAS falls for page hits", ras_falls - f0, 1);

    // R6: alternating rows reopen every time
    wait_ref();
    f0 = ras_falls;
    issue(1'b0, {11'h123, 10'h004}, 8'h00);
    issue(1'b0, corners[1], 8'h00);
    issue(1'b0, {11'h123, 10'h3FF}, 8'h00);
    issue(1'b0, corners[0], 8'h00);
    drain();
    check(ras_falls - f0 == 4, "R6", "RAS falls for row misses", ras_falls - f0, 4);

    // R9: long hit run is split by the RAS low cap
    wait_ref();
    f0 = ras_falls;
    for (int i = 0; i < 20; i++) issue(1'b0, {11'h123, 10'h004}, 8'h00);
    drain();
    check(ras_falls - f0 >= 2, "R9", "page reopened under cap", ras_falls - f0, 2);
    check(max_lo <= RAS_MAX, "R9", "longest RAS low", max_lo, RAS_MAX);

    // R8 R7: refresh interleaves with a continuous hit stream
    r0 = ref_cnt;
    for (int i = 0; i < 60; i++) begin
      issue(1'b1, {11'h2C7, 10'(i * 9)}, 8'(i ^ 8'h5A));
      issue(1'b0, {11'h2C7, 10'(i * 9)}, 8'h00);
    end
    drain();
    check(ref_cnt - r0 >= 1, "R8", "refreshes during hit stream", ref_cnt - r0, 1);
    check(ref_cnt >= cyc / REF_INT - 1, "R7", "refresh count", ref_cnt, cyc / REF_INT - 1);
    check(exp_q.size() == 0, "R4", "reads outstanding", exp_q.size(), 0);
    finish_run();
  end
endmodule